// File: doc/BRIEF.md
# Moving inversions memory test engine

This block is a self-test sequencer for a synchronous single-port RAM with a one-cycle read latency. After a start request it runs a chosen number of passes. Each pass has three phases. First a fill phase writes a data pattern to every word. Then an ascending sweep reads each word, checks it against the pattern and writes back its complement. Last, a descending sweep reads each word, checks it for that complement and writes the original pattern back.

Three pattern families are offered. The first is a solid word that alternates between zeros and ones from pass to pass. The second is a byte-wide walking value, copied into every byte of the word. The third is a single set bit that moves one place with each address, and whose starting place moves one place with each pass.

Every mismatch raises a one-cycle error pulse. The pulse carries the failing address, the expected word and the word that was read. The march does not stop on an error. A sticky fail flag and a saturating error counter summarise the run until the next start. The data width must be a power of two and a multiple of 8.

Top module: `march_bist`

## Requirements
- R1: After reset, busy, done, mem_en, err_pulse and fail are low and err_count is zero.
- R2: The fill phase writes the pass pattern P(a) to addresses 0 to 2^AW-1 in ascending order, one write per cycle.
- R3: The ascending sweep works through addresses 0 to 2^AW-1. Each address takes one read cycle and then one write cycle to the same address, and the write data is ~P(a).
- R4: The descending sweep works through addresses 2^AW-1 down to 0. Each address takes one read cycle, which expects ~P(a), and then one write cycle of P(a) to the same address. After address 0, the next pass begins with its fill phase.
- R5: Pattern mode 0 and mode 3 give P = all zeros on even pass numbers and all ones on odd pass numbers. Passes are counted from 0.
- R6: Pattern mode 1 uses k = pass mod 20 to pick a byte, which is copied into every byte of the word. For k < 8 the byte is 1<<k. For 8 <= k < 16 it is ~(1<<(k-8)). For k = 16, 17, 18 and 19 it is 8'h55, 8'hAA, 8'h33 and 8'hCC.
- R7: Pattern mode 2 gives P(a) = a single 1 at bit position (pass + a) mod DW.
- R8: A run executes passes+1 passes. In the cycle after the last write, done is high for exactly one cycle and busy and mem_en are low.
- R9: When a read returns data other than the expected word, err_pulse goes high in the cycle after the following write cycle. At that time err_addr, err_exp and err_act hold the failing address, the expected word and the read word. The march then continues unchanged.
- R10: fail sets on the first error and stays set until the next accepted start. err_count counts errors, saturates at 2^ECW-1 and is cleared by an accepted start.
- R11: start, mode and passes are sampled only while idle. Changing them during a run has no effect on the memory operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| mode | input | 2 | Pattern family: 0/3 solid, 1 byte walk, 2 rotating bit |
| passes | input | PW | Number of passes minus one |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after a read |
| err_pulse | output | 1 | One-cycle mismatch indication |
| err_addr | output | AW | Address of the last mismatch |
| err_exp | output | DW | Expected word of the last mismatch |
| err_act | output | DW | Word read at the last mismatch |
| fail | output | 1 | Sticky error flag for the current run |
| err_count | output | ECW | Saturating mismatch count |

## Verification
The assertions assume that mem_rdata comes from a RAM that returns a read in the next cycle and leaves the enable and address as issued. They also assume that start is the only way to clear the status. The bench keeps to this with a behavioural RAM model that has a one-cycle registered read. Faults are injected only as stuck-at-one bits on the read path, so stored contents stay coherent. The bench changes inputs shortly after the rising edge. It raises start in the middle of a run only to test that the request is ignored.

// File: rtl/march_bist.sv
module march_bist #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int PW  = 6,
  parameter int ECW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] passes,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          err_pulse,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_exp,
  output logic [DW-1:0] err_act,
  output logic          fail,
  output logic [ECW-1:0] err_count
);
  localparam logic [AW-1:0]  TOP  = '1;
  localparam int             RW   = $clog2(DW);
  localparam logic [ECW-1:0] CMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_UPR, S_UPW, S_DNR, S_DNW} st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [PW-1:0] pass, last;
  logic [1:0]    md;
  logic [4:0]    k20;
  logic [7:0]    bytev;
  logic [RW-1:0] rot;
  logic [DW-1:0] pat, expw;
  logic          chk, mism;

  always_comb begin
    if (k20 < 5'd8)       bytev = 8'd1 << k20[2:0];
    else if (k20 < 5'd16) bytev = ~(8'd1 << k20[2:0]);
    else begin
      case (k20[1:0])
        2'd0:    bytev = 8'h55;
        2'd1:    bytev = 8'hAA;
        2'd2:    bytev = 8'h33;
        default: bytev = 8'hCC;
      endcase
    end
  end

  assign rot = RW'(pass) + RW'(addr);

  always_comb begin
    case (md)
      2'd1:    pat = {(DW/8){bytev}};
      2'd2:    pat = DW'(1) << rot;
      default: pat = {DW{pass[0]}};
    endcase
  end

  assign chk       = (st == S_UPW) || (st == S_DNW);
  assign expw      = (st == S_UPW) ? pat : ~pat;
  assign mism      = chk && (mem_rdata != expw);
  assign busy      = st != S_IDLE;
  assign mem_en    = st != S_IDLE;
  assign mem_we    = (st == S_FILL) || chk;
  assign mem_addr  = addr;
  assign mem_wdata = (st == S_UPW) ? ~pat : pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= '0;
      pass      <= '0;
      last      <= '0;
      md        <= '0;
      k20       <= '0;
      done      <= 1'b0;
      err_pulse <= 1'b0;
      err_addr  <= '0;
      err_exp   <= '0;
      err_act   <= '0;
      fail      <= 1'b0;
      err_count <= '0;
    end else begin
      done      <= 1'b0;
      err_pulse <= mism;
      if (mism) begin
        err_addr <= addr;
        err_exp  <= expw;
        err_act  <= mem_rdata;
        fail     <= 1'b1;
        if (err_count != CMAX) err_count <= err_count + 1'b1;
      end
      case (st)
        S_IDLE: if (start) begin
          md        <= mode;
          last      <= passes;
          pass      <= '0;
          k20       <= '0;
          addr      <= '0;
          fail      <= 1'b0;
          err_count <= '0;
          st        <= S_FILL;
        end
        S_FILL: begin
          addr <= addr + 1'b1;
          if (addr == TOP) st <= S_UPR;
        end
        S_UPR: st <= S_UPW;
        S_UPW: begin
          if (addr == TOP) st <= S_DNR;
          else begin
            addr <= addr + 1'b1;
            st   <= S_UPR;
          end
        end
        S_DNR: st <= S_DNW;
        S_DNW: begin
          if (addr == '0) begin
            if (pass == last) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              pass <= pass + 1'b1;
              k20  <= (k20 == 5'd19) ? 5'd0 : k20 + 5'd1;
              st   <= S_FILL;
            end
          end else begin
            addr <= addr - 1'b1;
            st   <= S_DNR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/march_bist_sva.sv
module march_bist_chk #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int ECW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           mem_en,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic           err_pulse,
  input logic           fail,
  input logic [ECW-1:0] err_count
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && !mem_en)); // R8
  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_en); // R2
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_we && mem_addr == $past(mem_addr))); // R3
  AST_ERR_RECORDED: assert property (@(posedge clk) disable iff (!rst_n) err_pulse |-> (fail && err_count != '0)); // R10
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (fail && !start) |=> fail); // R10
  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n) !start |=> (err_count >= $past(err_count))); // R10
endmodule

bind march_bist march_bist_chk #(.AW(AW), .DW(DW), .ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
  .err_pulse(err_pulse), .fail(fail), .err_count(err_count)
);

// File: tb/tb_march_bist.sv
module tb_march_bist;
  localparam int AW = 4, DW = 32, PW = 6, ECW = 3, D = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [PW-1:0] passes = '0;
  logic busy, done, mem_en, mem_we, err_pulse, fail;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, err_exp, err_act;
  logic [DW-1:0] mem_rdata = '0;
  logic [ECW-1:0] err_count;

  march_bist #(.AW(AW), .DW(DW), .PW(PW), .ECW(ECW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .passes(passes),
    .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_pulse(err_pulse), .err_addr(err_addr), .err_exp(err_exp),
    .err_act(err_act), .fail(fail), .err_count(err_count));

  logic [DW-1:0] mem [D];
  logic [DW-1:0] fmask = '0;
  logic fall = 1'b0;
  logic [AW-1:0] faddr = '0;

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr] | ((fall || mem_addr == faddr) ? fmask : '0);
    end

  typedef struct packed { logic we; logic [AW-1:0] a; logic [DW-1:0] d; } op_t;
  op_t q[$];
  string qt[$];
  string mtag = "R5";
  int nt = 0, nf = 0, m_cnt = 0;
  bit running = 0, pred_err = 0, m_fail = 0, rd_pend = 0;
  logic [AW-1:0] p_addr = '0, rd_a = '0;
  logic [DW-1:0] p_exp = '0, p_act = '0, rd_e = '0;

  task automatic check(input bit ok, input string msg);
    nt++;
    if (!ok) begin nf++; $display("FAIL %s", msg); end
  endtask

  // Pattern rules: R5 solid, R6 byte walk, R7 rotating bit
  function automatic logic [DW-1:0] pat(input int md, input int p, input int a);
    logic [7:0] b;
    int k;
    k = p % 20;
    if (md == 1) begin
      if (k < 8) b = 8'(1 << k);
      else if (k < 16) b = ~8'(1 << (k - 8));
      else if (k == 16) b = 8'h55;
      else if (k == 17) b = 8'hAA;
      else if (k == 18) b = 8'h33;
      else b = 8'hCC;
      return {4{b}};
    end else if (md == 2) return 32'(1) << ((p + a) % 32);
    else return (p % 2 == 1) ? '1 : '0;
  endfunction

  task automatic build(input int md, input int np);
    for (int p = 0; p <= np; p++) begin
      for (int a = 0; a < D; a++) begin
        q.push_back('{1'b1, AW'(a), pat(md, p, a)}); qt.push_back("R2");
      end
      for (int a = 0; a < D; a++) begin
        q.push_back('{1'b0, AW'(a), pat(md, p, a)}); qt.push_back("R3");
        q.push_back('{1'b1, AW'(a), ~pat(md, p, a)}); qt.push_back("R3");
      end
      for (int a = D - 1; a >= 0; a--) begin
        q.push_back('{1'b0, AW'(a), ~pat(md, p, a)}); qt.push_back("R4");
        q.push_back('{1'b1, AW'(a), pat(md, p, a)}); qt.push_back("R4");
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    op_t o;
    string t;
    check(err_pulse == pred_err && (!pred_err || (err_addr == p_addr && err_exp == p_exp && err_act == p_act)),
      $sformatf("R9 pulse=%0b addr=%0d exp=%h act=%h, expected pulse=%0b addr=%0d exp=%h act=%h",
        err_pulse, err_addr, err_exp, err_act, pred_err, p_addr, p_exp, p_act));
    check(int'(err_count) == m_cnt && fail == m_fail,
      $sformatf("R10 count=%0d fail=%0b, expected count=%0d fail=%0b", err_count, fail, m_cnt, m_fail));
    pred_err = 0;
    if (running) begin
      if (q.size() > 0) begin
        o = q.pop_front();
        t = qt.pop_front();
        check(mem_en && mem_we == o.we && mem_addr == o.a && (!o.we || mem_wdata == o.d),
          $sformatf("%s/%s en=%0b we=%0b addr=%0d wdata=%h, expected en=1 we=%0b addr=%0d data=%h",
            t, mtag, mem_en, mem_we, mem_addr, mem_wdata, o.we, o.a, o.d));
        if (!o.we) begin
          rd_pend = 1; rd_a = o.a; rd_e = o.d;
        end else if (rd_pend) begin
          rd_pend = 0;
          if (mem_rdata !== rd_e) begin
            pred_err = 1; p_addr = rd_a; p_exp = rd_e; p_act = mem_rdata;
            m_fail = 1;
            if (m_cnt < 7) m_cnt++;
          end
        end
      end else begin
        check(done && !busy && !mem_en,
          $sformatf("R8 end done=%0b busy=%0b en=%0b, expected done=1 busy=0 en=0", done, busy, mem_en));
        running = 0;
      end
    end else begin
      check(!done && !busy && !mem_en,
        $sformatf("R8 idle done=%0b busy=%0b en=%0b, expected 0 0 0", done, busy, mem_en));
      if (start) begin
        build(int'(mode), int'(passes));
        mtag = (mode == 2'd1) ? "R6" : (mode == 2'd2) ? "R7" : "R5";
        m_cnt = 0; m_fail = 0; rd_pend = 0;
        running = 1;
      end
    end
  end

  task automatic run(input int md, input int np, input bit poke);
    @(posedge clk); #1 start = 1; mode = 2'(md); passes = PW'(np);
    @(posedge clk); #1 start = 0;
    if (poke) begin
      // R11: new request and config mid-run must be ignored
      repeat (37) @(posedge clk);
      #1 start = 1; mode = 2'(md + 1); passes = PW'(np + 5);
      @(posedge clk); #1 start = 0;
    end
    wait (!running);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !mem_en && !err_pulse && !fail && err_count == '0,
      $sformatf("R1 busy=%0b done=%0b en=%0b pulse=%0b fail=%0b cnt=%0d, expected all zero",
        busy, done, mem_en, err_pulse, fail, err_count));
    run(0, 1, 0);                       // R5 solid, two passes
    run(1, 21, 0);                      // R6 byte walk, wraps past 20
    run(2, 33, 0);                      // R7 rotating bit, beyond DW passes
    faddr = 5; fmask = 32'h8;
    run(2, 1, 1);                       // R9 single faulty word, R11 poke
    fall = 1; fmask = 32'h1;
    run(0, 3, 0);                       // R10 saturation
    check(err_count == 3'd7 && fail,
      $sformatf("R10 saturated cnt=%0d fail=%0b, expected cnt=7 fail=1", err_count, fail));
    fall = 0; fmask = '0;
    run(3, 0, 0);                       // R5 mode 3, R10 cleared by start
    check(err_count == '0 && !fail,
      $sformatf("R10 cleared cnt=%0d fail=%0b, expected cnt=0 fail=0", err_count, fail));
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nt++; nf++;
    $display("FAIL watchdog expired, actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", nt, nf);
    $finish;
  end
endmodule